// File: doc/BRIEF.md
# Phase-Locked Clock and Strobe Generator with Programmable Shifts

The block takes one reference clock running at twice the master rate. From it, one free-running half-period counter produces every internal timing signal of a sensor-style readout path. The outputs are a serializer clock at the master rate, a checksum clock at one quarter of that rate, a one-tick load strobe that hands checksum words to the serializer, and a converter clock at one eighth of the master rate. It also produces two shifted clocks: a sensor clock at one quarter rate and a second converter clock at one eighth rate. Each of these two has its own delay code, counted in half master periods.

Both delay codes sit in one configuration register, which is loaded through a write-enable and data port. A code is not applied at the moment it is written. It is applied only at a boundary of the divided period it governs, so each divided period uses a single setting. Every output comes from a flop fed by the same counter, so all outputs stay phase-locked to the serializer clock.

Top module: `mclk_phase_gen`

## Requirements
- R1: Number the reference edges after reset release from k = 0, and let phase n = k mod 16 describe the outputs after edge k. The serializer output is high exactly when n is odd, so it toggles on every reference edge.
- R2: The checksum clock is high exactly when (n mod 8) is 4, 5, 6 or 7. Its period is 8 reference cycles, which is 4 master periods.
- R3: The load strobe is high for exactly one reference cycle out of every 8 (12.5 %), when (n mod 8) = 3. This is the cycle just before the checksum clock rises.
- R4: The plain converter clock is high exactly when n is 8 or more. Its period is 16 reference cycles, and every edge of it coincides with a falling edge of the checksum clock.
- R5: The shifted sensor clock is high exactly when ((n − s) mod 8) ≥ 4, where s is the applied sensor code. Codes 8 to 15 wrap, so they act as s − 8. Code 0 gives the checksum clock waveform.
- R6: The shifted converter clock is high exactly when ((n − c) mod 16) ≥ 8, where c is the applied converter code (0 to 15).
- R7: Configuration data bits [3:0] hold the sensor code and bits [7:4] hold the converter code. A write is captured on the edge where the write enable is high. A new sensor code governs the outputs from the first edge with (n mod 8) = 0 that lies at least two edges after the write edge. A new converter code does the same from the first edge with n = 0 that lies at least two edges after the write edge. Until then the old code stays in force.
- R8: While reset is high on an edge, the counter returns to zero, both codes return to 0, and every output is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Reference clock at twice the master rate |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Write enable for the delay configuration register |
| cfg_wdata_i | input | 8 | Delay codes: [3:0] sensor, [7:4] converter |
| ser_clk_o | output | 1 | Serializer clock, master rate |
| chk_clk_o | output | 1 | Checksum clock, one quarter rate |
| load_o | output | 1 | One-tick handoff strobe, one quarter rate |
| adc_clk_o | output | 1 | Converter clock, one eighth rate |
| sen_clk_o | output | 1 | Shifted sensor clock, one quarter rate |
| adc_dly_clk_o | output | 1 | Shifted converter clock, one eighth rate |

## Verification
A reference model in the bench predicts all six outputs on every edge. The run starts with both codes at zero, which shows whether the base ratios and the strobe position are right apart from any shifting. Next come codes of 3 and 5 written partway through a period, which show whether an update waits for its own boundary: the sensor boundary falls every 8 edges and the converter boundary every 16. Codes 15, 8 and 9 show whether the sensor path wraps modulo 8 while the converter path uses the full range. A pseudo-random series of writes at random moments, followed by a reset in the middle of the run, covers the remaining combinations of phase and code.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    localparam int unsigned MPG_CNT_W = 4;  // half-period counter width
    localparam int unsigned MPG_DLY_W = 4;  // width of one delay code
    localparam int unsigned MPG_CHK_P = 3;  // log2 of checksum period in ticks

    // Fixed (unshifted) timing outputs, registered together
    typedef struct packed {
        logic ser;
        logic chk;
        logic load;
        logic adc;
    } mpg_base_t;

endpackage

// File: rtl/mpg_counter.sv
module mpg_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] phase_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase_o = st_q.cnt;

endmodule

// File: rtl/mpg_cfg_reg.sv
module mpg_cfg_reg #(
    parameter int unsigned DLY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [2*DLY_W-1:0] wdata_i,
    output logic [DLY_W-1:0]   sen_code_o,
    output logic [DLY_W-1:0]   adc_code_o
);

    typedef struct packed {
        logic [DLY_W-1:0] adc_code;
        logic [DLY_W-1:0] sen_code;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.sen_code = wdata_i[DLY_W-1:0];
            st_d.adc_code = wdata_i[2*DLY_W-1:DLY_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sen_code_o = st_q.sen_code;
    assign adc_code_o = st_q.adc_code;

endmodule

// File: rtl/mpg_base_div.sv
module mpg_base_div
    import mpg_pkg::*;
#(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned CHK_P      = 3,
    parameter int unsigned LOAD_PHASE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] phase_i,
    output mpg_base_t        base_o
);

    localparam logic [CHK_P-1:0] LOAD_AT = CHK_P'(LOAD_PHASE);

    mpg_base_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ser  = phase_i[0];
        st_d.chk  = phase_i[CHK_P-1];
        st_d.adc  = phase_i[CNT_W-1];
        st_d.load = (phase_i[CHK_P-1:0] == LOAD_AT);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign base_o = st_q;

endmodule

// File: rtl/mpg_shifted_div.sv
module mpg_shifted_div #(
    parameter int unsigned P     = 3,
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [P-1:0]     phase_i,
    input  logic [DLY_W-1:0] code_i,
    output logic             clk_o,
    output logic [DLY_W-1:0] applied_o
);

    localparam logic [P-1:0] LAST = {P{1'b1}};

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             out;
    } sdiv_state_t;

    sdiv_state_t  st_d, st_q;
    logic [P-1:0] lag;

    always_comb begin
        st_d    = st_q;
        lag     = phase_i - P'(st_q.dly);
        st_d.out = lag[P-1];
        if (phase_i == LAST) st_d.dly = code_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign clk_o     = st_q.out;
    assign applied_o = st_q.dly;

endmodule

// File: rtl/mclk_phase_gen.sv
module mclk_phase_gen
    import mpg_pkg::*;
#(
    parameter int unsigned CNT_W      = MPG_CNT_W,
    parameter int unsigned DLY_W      = MPG_DLY_W,
    parameter int unsigned CHK_P      = MPG_CHK_P,
    parameter int unsigned LOAD_PHASE = 3
) (
    input  logic               clk2x_i,
    input  logic               rst_i,
    input  logic               cfg_we_i,
    input  logic [2*DLY_W-1:0] cfg_wdata_i,
    output logic               ser_clk_o,
    output logic               chk_clk_o,
    output logic               load_o,
    output logic               adc_clk_o,
    output logic               sen_clk_o,
    output logic               adc_dly_clk_o
);

    logic [CNT_W-1:0] phase;
    logic [DLY_W-1:0] sen_code, adc_code;
    logic [DLY_W-1:0] sen_applied, adc_applied;
    mpg_base_t        base;

    mpg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk2x_i),
        .rst     (rst_i),
        .phase_o (phase)
    );

    mpg_cfg_reg #(.DLY_W(DLY_W)) u_cfg (
        .clk        (clk2x_i),
        .rst        (rst_i),
        .we_i       (cfg_we_i),
        .wdata_i    (cfg_wdata_i),
        .sen_code_o (sen_code),
        .adc_code_o (adc_code)
    );

    mpg_base_div #(
        .CNT_W      (CNT_W),
        .CHK_P      (CHK_P),
        .LOAD_PHASE (LOAD_PHASE)
    ) u_base (
        .clk     (clk2x_i),
        .rst     (rst_i),
        .phase_i (phase),
        .base_o  (base)
    );

    mpg_shifted_div #(.P(CHK_P), .DLY_W(DLY_W)) u_sen (
        .clk       (clk2x_i),
        .rst       (rst_i),
        .phase_i   (phase[CHK_P-1:0]),
        .code_i    (sen_code),
        .clk_o     (sen_clk_o),
        .applied_o (sen_applied)
    );

    mpg_shifted_div #(.P(CNT_W), .DLY_W(DLY_W)) u_adcd (
        .clk       (clk2x_i),
        .rst       (rst_i),
        .phase_i   (phase),
        .code_i    (adc_code),
        .clk_o     (adc_dly_clk_o),
        .applied_o (adc_applied)
    );

    assign ser_clk_o = base.ser;
    assign chk_clk_o = base.chk;
    assign load_o    = base.load;
    assign adc_clk_o = base.adc;

endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned DLY_W = 4,
    parameter int unsigned CHK_P = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ser,
    input logic             chk,
    input logic             load,
    input logic             adc,
    input logic             sen,
    input logic             adcd,
    input logic [CNT_W-1:0] phase,
    input logic [DLY_W-1:0] sen_applied,
    input logic [DLY_W-1:0] adc_applied
);

    logic [1:0] settle_q;
    logic       settled;

    always_ff @(posedge clk) begin
        if (rst)                   settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    assign settled = (settle_q >= 2'd2);

    p_ser_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        settled |-> (ser != $past(ser)));

    p_chk_after_load_r2: assert property (@(posedge clk) disable iff (rst)
        (settled && $rose(chk)) |-> $past(load));

    p_load_single_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    p_adc_on_chk_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (settled && (adc != $past(adc))) |-> $fell(chk));

    p_sen_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (settled && (sen_applied != $past(sen_applied))) |-> (phase[CHK_P-1:0] == '0));

    p_adc_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (settled && (adc_applied != $past(adc_applied))) |-> (phase == '0));

    p_reset_low_r8: assert property (@(posedge clk)
        rst |=> ({ser, chk, load, adc, sen, adcd} == 6'b0 && phase == '0));

endmodule

bind mclk_phase_gen mpg_checker #(
    .CNT_W (CNT_W),
    .DLY_W (DLY_W),
    .CHK_P (CHK_P)
) u_mpg_checker (
    .clk         (clk2x_i),
    .rst         (rst_i),
    .ser         (ser_clk_o),
    .chk         (chk_clk_o),
    .load        (load_o),
    .adc         (adc_clk_o),
    .sen         (sen_clk_o),
    .adcd        (adc_dly_clk_o),
    .phase       (phase),
    .sen_applied (sen_applied),
    .adc_applied (adc_applied)
);

// File: tb/mclk_phase_gen_bench.sv
module mclk_phase_gen_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we  = 1'b0;
    logic [7:0] wdata = '0;
    logic       ser, chk, load, adc, sen, adcd;

    int n_cmp  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mclk_phase_gen u_mclk_phase_gen (
        .clk2x_i       (clk),
        .rst_i         (rst),
        .cfg_we_i      (we),
        .cfg_wdata_i   (wdata),
        .ser_clk_o     (ser),
        .chk_clk_o     (chk),
        .load_o        (load),
        .adc_clk_o     (adc),
        .sen_clk_o     (sen),
        .adc_dly_clk_o (adcd)
    );

    // Reference model state, advanced at each reference edge
    int   m_n  = 0;   // phase 0..15
    int   m_s  = 0;   // applied sensor code
    int   m_c  = 0;   // applied converter code
    int   m_cs = 0;   // stored sensor code
    int   m_cc = 0;   // stored converter code
    logic [6:0] exp_q[$];  // {in_reset, ser, chk, load, adc, sen, adcd}

    always @(posedge clk) begin
        logic [5:0] e;
        if (rst) begin
            m_n = 0; m_s = 0; m_c = 0; m_cs = 0; m_cc = 0;
            exp_q.push_back({1'b1, 6'b0});                 // R8
        end else begin
            e[5] = (m_n % 2) == 1;                         // R1
            e[4] = (m_n % 8) >= 4;                         // R2
            e[3] = (m_n % 8) == 3;                         // R3
            e[2] = m_n >= 8;                               // R4
            e[1] = ((m_n - (m_s % 8) + 8) % 8) >= 4;       // R5
            e[0] = ((m_n - m_c + 16) % 16) >= 8;           // R6
            exp_q.push_back({1'b0, e});
            // R7: stored codes move to applied at the last edge of each period
            if ((m_n % 8) == 7) m_s = m_cs;
            if (m_n == 15)      m_c = m_cc;
            if (we) begin m_cs = wdata[3:0]; m_cc = wdata[7:4]; end
            m_n = (m_n + 1) % 16;
        end
    end

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        logic [6:0] it;
        logic [5:0] act;
        string tags[6];
        tags[0] = "R6/R7"; tags[1] = "R5/R7"; tags[2] = "R4";
        tags[3] = "R3";    tags[4] = "R2";    tags[5] = "R1";
        if (exp_q.size() > 0) begin
            it  = exp_q.pop_front();
            act = {ser, chk, load, adc, sen, adcd};
            for (int b = 0; b < 6; b++) begin
                n_cmp++;
                if (act[b] !== it[b]) begin
                    n_fail++;
                    $display("FAIL %s bit %0d at cycle %0d: actual %b expected %b",
                             it[6] ? "R8" : tags[b], b, cycles, act[b], it[b]);
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [3:0] s, input logic [3:0] c);
        @(negedge clk);
        we    = 1'b1;
        wdata = {c, s};
        @(negedge clk);
        we    = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        int lcg = 32'h1234_5677;
        tick(4);
        rst = 1'b0;
        tick(40);                           // codes zero: base ratios, R1..R4
        tick(5);
        write_cfg(4'd3, 4'd5);              // mid-period write, R7
        tick(40);
        write_cfg(4'd15, 4'd15);            // sensor wraps, R5
        tick(37);
        write_cfg(4'd8, 4'd0);
        tick(33);
        write_cfg(4'd9, 4'd7);
        tick(41);
        for (int k = 0; k < 30; k++) begin
            lcg = lcg * 1103515245 + 12345;
            write_cfg(lcg[19:16], lcg[23:20]);
            tick(lcg[27:24] + 1);
        end
        write_cfg(4'd6, 4'd11);
        tick(7);
        rst = 1'b1;                         // mid-run reset, R8
        tick(3);
        rst = 1'b0;
        tick(40);
        write_cfg(4'd1, 4'd2);
        tick(50);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule